// File: doc/BRIEF.md
# Phase-Offset PWM Generator with Staged Commit

This block produces one pulse-width-modulated output whose period, high time and phase within the period are each counted in cycles of its own clock. The values are `CNT_W` bits wide, 32 by default. Software writes new settings into staged copies through a simple single-cycle register port. The settings only move into the live generator after a commit request, and only where a period ends. A waveform that is already running therefore never shows a partly updated period.

The generator can repeat periods without limit, or run a programmed number of periods and then stop and raise a completion flag. The flag can drive an interrupt line through a mask. Clearing either of the two run-enable bits freezes the counter and the output pin where they are. Setting both bits again resumes from the same point.

The controller has three states. **IDLE** follows reset. **RUN** generates periods. **DONE** follows a finished one-shot sequence. The transitions are:
- *launch* (IDLE→RUN and DONE→RUN): both enables are set and a commit is pending. The staged values load at once and the count starts at 0.
- *reload* (RUN→RUN): at the last cycle of a period a commit is pending. The staged values load and the one-shot repetition count restarts.
- *finish* (RUN→DONE): at the last cycle of the final one-shot period no commit is pending.

Top module: `pwm_phase_gen`

## Requirements
- R1: After reset the output and the interrupt line are low, all registers read back as 0, and no commit is pending.
- R2: The period length is P cycles. The output is high during the count positions c with O <= c < O+D, where P, D and O are the period, high time and offset that have been loaded. After a launch written at clock edge E0, the output shows count position k from clock edge E0+2+k onwards.
- R3: When the period, high time and offset load, the offset is limited to P-D. If D >= P, the offset becomes 0 and the output stays high for the whole period.
- R4: A loaded period of 0 holds the output low.
- R5: Writes to the staged period (address 1), high time (address 2), offset (address 3) and mode (address 4) do not change the output until a commit takes effect. A commit made in the middle of a period takes effect at the end of that period, which finishes with the old values.
- R6: The enable register is at address 0. Bit 2 of this register requests a commit. It reads back as 1 while the commit is pending and clears itself when the staged values load.
- R7: Writes to address 0 change bit i (i = 0 output enable, 1 clock enable, 2 commit) only when write-data bit i+16 is 1. A write with all mask bits at 0 changes nothing.
- R8: The generator runs only while bits 0 and 1 are both 1. When either bit is cleared, the counter and the output hold their values. When both bits are set again, the generator continues from the held count.
- R9: The mode register is at address 4. Bit 0 = 1 selects one-shot mode and bits 31:16 hold a repetition count R, where 0 counts as 1. After R periods the generator enters DONE, the output goes low, and the completion status sets on the final edge of the last period.
- R10: The completion status is bit 0 of address 5 and is cleared by writing 1 to that bit. The mask is bit 0 of address 6. The interrupt output equals status AND mask.
- R11: Reading addresses 1 to 4 returns the last values written to them, before any limiting of the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | generator and register clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_we | input | 1 | register write strobe, one cycle per write |
| bus_addr | input | 3 | register address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for `bus_addr`, combinational |
| pwm_out | output | 1 | modulated output |
| irq | output | 1 | masked completion interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit period, high time and offset, and a 16-bit repetition count. At these widths the limited and unlimited offsets read back with full values. The stimulus uses short periods of 0 to 16 cycles, so every commit lands at a period end within a few dozen cycles. These short periods reach the corner cases: an offset that must be limited, a high time equal to the period, a zero period, a commit in the middle of a period, a freeze while the output is high, and one-shot runs with R=3 and R=0.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } gen_state_e;

    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned MASK_SH = 16;

    // register addresses
    localparam logic [ADDR_W-1:0] A_ENABLE = 3'd0;
    localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
    localparam logic [ADDR_W-1:0] A_DUTY   = 3'd2;
    localparam logic [ADDR_W-1:0] A_OFFSET = 3'd3;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd4;
    localparam logic [ADDR_W-1:0] A_ISTAT  = 3'd5;
    localparam logic [ADDR_W-1:0] A_IMASK  = 3'd6;

    // bit positions inside the enable register
    localparam int unsigned EN_OUT    = 0;
    localparam int unsigned EN_CLK    = 1;
    localparam int unsigned EN_COMMIT = 2;

    // mode register: one-shot flag and repetition field base
    localparam int unsigned MODE_ONESHOT = 0;
    localparam int unsigned MODE_REP_LSB = 16;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_phase_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned REP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              commit_take,
    input  logic              done_pulse,
    output logic [CNT_W-1:0]  sh_period,
    output logic [CNT_W-1:0]  sh_duty,
    output logic [CNT_W-1:0]  sh_offset,
    output logic              sh_oneshot,
    output logic [REP_W-1:0]  sh_reps,
    output logic              run,
    output logic              commit_pend,
    output logic              irq_stat,
    output logic              irq_mask
);

    logic out_en;
    logic clk_en;

    assign run = out_en & clk_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_en      <= 1'b0;
            clk_en      <= 1'b0;
            commit_pend <= 1'b0;
            sh_period   <= '0;
            sh_duty     <= '0;
            sh_offset   <= '0;
            sh_oneshot  <= 1'b0;
            sh_reps     <= '0;
            irq_stat    <= 1'b0;
            irq_mask    <= 1'b0;
        end else begin
            if (commit_take) begin
                commit_pend <= 1'b0;
            end
            if (bus_we) begin
                case (bus_addr)
                    A_ENABLE: begin
                        if (bus_wdata[MASK_SH + EN_OUT]) out_en <= bus_wdata[EN_OUT];
                        if (bus_wdata[MASK_SH + EN_CLK]) clk_en <= bus_wdata[EN_CLK];
                        if (bus_wdata[MASK_SH + EN_COMMIT] && bus_wdata[EN_COMMIT]) begin
                            commit_pend <= 1'b1;
                        end
                    end
                    A_PERIOD: sh_period <= bus_wdata[CNT_W-1:0];
                    A_DUTY:   sh_duty   <= bus_wdata[CNT_W-1:0];
                    A_OFFSET: sh_offset <= bus_wdata[CNT_W-1:0];
                    A_MODE: begin
                        sh_oneshot <= bus_wdata[MODE_ONESHOT];
                        sh_reps    <= bus_wdata[MODE_REP_LSB +: REP_W];
                    end
                    A_ISTAT: if (bus_wdata[0]) irq_stat <= 1'b0;
                    A_IMASK: irq_mask <= bus_wdata[0];
                    default: ;
                endcase
            end
            // a completion in the same cycle as a clear wins
            if (done_pulse) begin
                irq_stat <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_ENABLE: begin
                bus_rdata[EN_OUT]    = out_en;
                bus_rdata[EN_CLK]    = clk_en;
                bus_rdata[EN_COMMIT] = commit_pend;
            end
            A_PERIOD: bus_rdata = DATA_W'(sh_period);
            A_DUTY:   bus_rdata = DATA_W'(sh_duty);
            A_OFFSET: bus_rdata = DATA_W'(sh_offset);
            A_MODE: begin
                bus_rdata[MODE_ONESHOT]         = sh_oneshot;
                bus_rdata[MODE_REP_LSB +: REP_W] = sh_reps;
            end
            A_ISTAT: bus_rdata[0] = irq_stat;
            A_IMASK: bus_rdata[0] = irq_mask;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_phase_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned REP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             commit_pend,
    input  logic [CNT_W-1:0] sh_period,
    input  logic [CNT_W-1:0] sh_duty,
    input  logic [CNT_W-1:0] sh_offset,
    input  logic             sh_oneshot,
    input  logic [REP_W-1:0] sh_reps,
    output logic             commit_take,
    output logic             done_pulse,
    output logic             pwm_out,
    output gen_state_e       state,
    output logic [CNT_W-1:0] act_period,
    output logic [CNT_W-1:0] act_duty,
    output logic [CNT_W-1:0] act_offset
);

    gen_state_e       st_nxt;
    logic [CNT_W-1:0] cnt;
    logic             act_oneshot;
    logic [REP_W-1:0] act_reps;
    logic [REP_W-1:0] rep_cnt;
    logic [REP_W:0]   reps_need;
    logic [REP_W:0]   rep_next;
    logic             boundary;
    logic             last_rep;
    logic             launch;
    logic             reload;
    logic             finish;
    logic             hit;
    logic             pwm_q;
    logic [CNT_W-1:0] load_off;

    function automatic logic [CNT_W-1:0] limit_offset(
        input logic [CNT_W-1:0] p,
        input logic [CNT_W-1:0] d,
        input logic [CNT_W-1:0] o
    );
        if (d >= p)         return '0;
        else if (o > p - d) return p - d;
        else                return o;
    endfunction

    assign load_off  = limit_offset(sh_period, sh_duty, sh_offset);
    assign boundary  = (act_period == '0) || (cnt == act_period - CNT_W'(1));
    assign reps_need = (act_reps == '0) ? (REP_W+1)'(1) : {1'b0, act_reps};
    assign rep_next  = {1'b0, rep_cnt} + (REP_W+1)'(1);
    assign last_rep  = act_oneshot && (rep_next >= reps_need);
    assign launch    = run && commit_pend && (state != ST_RUN);
    assign reload    = run && (state == ST_RUN) && boundary && commit_pend;
    assign finish    = run && (state == ST_RUN) && boundary && !commit_pend && last_rep;
    assign hit       = (act_period != '0) && (cnt >= act_offset)
                       && ((cnt - act_offset) < act_duty);

    assign commit_take = launch || reload;
    assign done_pulse  = finish;
    assign pwm_out     = pwm_q;

    // next-state decode
    always_comb begin
        st_nxt = state;
        unique case (state)
            ST_IDLE, ST_DONE: if (launch) st_nxt = ST_RUN;
            ST_RUN:           if (finish) st_nxt = ST_DONE;
            default:          st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= st_nxt;
        end
    end

    // counter, live settings and output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            rep_cnt     <= '0;
            act_period  <= '0;
            act_duty    <= '0;
            act_offset  <= '0;
            act_oneshot <= 1'b0;
            act_reps    <= '0;
            pwm_q       <= 1'b0;
        end else if (run) begin
            if (commit_take) begin
                act_period  <= sh_period;
                act_duty    <= sh_duty;
                act_offset  <= load_off;
                act_oneshot <= sh_oneshot;
                act_reps    <= sh_reps;
            end
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    pwm_q <= 1'b0;
                    if (launch) begin
                        cnt     <= '0;
                        rep_cnt <= '0;
                    end
                end
                ST_RUN: begin
                    pwm_q <= hit;
                    if (boundary) begin
                        cnt     <= '0;
                        rep_cnt <= reload ? '0 : rep_next[REP_W-1:0];
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: pwm_q <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
    import pwm_phase_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned REP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out,
    output logic              irq
);

    logic             run;
    logic             commit_pend;
    logic             commit_take;
    logic             done_pulse;
    logic             irq_stat;
    logic             irq_mask;
    logic [CNT_W-1:0] sh_period;
    logic [CNT_W-1:0] sh_duty;
    logic [CNT_W-1:0] sh_offset;
    logic             sh_oneshot;
    logic [REP_W-1:0] sh_reps;
    logic [CNT_W-1:0] act_period;
    logic [CNT_W-1:0] act_duty;
    logic [CNT_W-1:0] act_offset;
    gen_state_e       state;

    pwm_regs #(.CNT_W(CNT_W), .REP_W(REP_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .commit_take (commit_take),
        .done_pulse  (done_pulse),
        .sh_period   (sh_period),
        .sh_duty     (sh_duty),
        .sh_offset   (sh_offset),
        .sh_oneshot  (sh_oneshot),
        .sh_reps     (sh_reps),
        .run         (run),
        .commit_pend (commit_pend),
        .irq_stat    (irq_stat),
        .irq_mask    (irq_mask)
    );

    pwm_core #(.CNT_W(CNT_W), .REP_W(REP_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .commit_pend (commit_pend),
        .sh_period   (sh_period),
        .sh_duty     (sh_duty),
        .sh_offset   (sh_offset),
        .sh_oneshot  (sh_oneshot),
        .sh_reps     (sh_reps),
        .commit_take (commit_take),
        .done_pulse  (done_pulse),
        .pwm_out     (pwm_out),
        .state       (state),
        .act_period  (act_period),
        .act_duty    (act_duty),
        .act_offset  (act_offset)
    );

    assign irq = irq_stat & irq_mask;

endmodule

// File: rtl/pwm_phase_gen_chk.sv
module pwm_phase_gen_chk
    import pwm_phase_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              pwm_out,
    input logic              commit_take,
    input logic              commit_pend,
    input logic              done_pulse,
    input logic              irq_stat,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input gen_state_e        state,
    input logic [CNT_W-1:0]  act_period,
    input logic [CNT_W-1:0]  act_duty,
    input logic [CNT_W-1:0]  act_offset
);

    logic commit_req;
    assign commit_req = bus_we && (bus_addr == A_ENABLE)
                        && bus_wdata[MASK_SH + EN_COMMIT] && bus_wdata[EN_COMMIT];

    // R3: live offset never passes period minus high time
    assert_offset_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_duty < act_period) |-> (act_offset <= act_period - act_duty));

    // R4: a zero period in RUN drives the output low
    assert_zero_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == ST_RUN && act_period == '0) |=> !pwm_out);

    // R6: a taken commit leaves nothing pending unless re-requested
    assert_commit_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_take && !commit_req) |=> !commit_pend);

    // R8: while not running the output holds
    assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(pwm_out));

    // R9: DONE drives the output low
    assert_done_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state == ST_DONE) |=> !pwm_out);

    // R10: completion always sets the status flag
    assert_done_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> irq_stat);

endmodule

bind pwm_phase_gen pwm_phase_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .pwm_out     (pwm_out),
    .commit_take (commit_take),
    .commit_pend (commit_pend),
    .done_pulse  (done_pulse),
    .irq_stat    (irq_stat),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .state       (state),
    .act_period  (act_period),
    .act_duty    (act_duty),
    .act_offset  (act_offset)
);

// File: tb/test_pwm_phase_gen.sv
module test_pwm_phase_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    // period, high time, offset written, expected live offset
    localparam logic [31:0] VEC [0:NV-1][0:3] = '{
        '{32'd8,  32'd3, 32'd7,  32'd5},   // R3 offset limited
        '{32'd12, 32'd4, 32'd0,  32'd0},   // R2
        '{32'd6,  32'd6, 32'd3,  32'd0},   // R3 high time equals period
        '{32'd0,  32'd3, 32'd1,  32'd0},   // R4 zero period
        '{32'd9,  32'd2, 32'd4,  32'd4},   // R2
        '{32'd16, 32'd5, 32'd20, 32'd11}   // R3 large offset
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;
    logic        irq;

    int          n_vec = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;
    bit          track = 1'b0;
    bit          pend_valid = 1'b0;
    logic [31:0] ep = '0, ed = '0, eo = '0;
    logic [31:0] np = '0, nd = '0, no = '0;
    logic [31:0] kk = '0;
    string       cur_tag = "R2";

    pwm_phase_gen i_pwm_phase_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_level(logic [31:0] k, logic [31:0] p, logic [31:0] d, logic [31:0] o);
        if (p == 0) return 1'b0;
        return (k >= o) && ((k - o) < d);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp, string what);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        if (track) begin
            chk(cur_tag, 32'(pwm_out), 32'(exp_level(kk, ep, ed, eo)), "pwm_out level");
            kk = kk + 1;
            if (ep == 0 || kk == ep) begin
                kk = 0;
                if (pend_valid) begin
                    ep = np; ed = nd; eo = no;
                    pend_valid = 1'b0;
                end
            end
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic stage(logic [31:0] p, logic [31:0] d, logic [31:0] o,
                         logic [31:0] eff, logic [31:0] mode);
        wr(3'd1, p);
        wr(3'd2, d);
        wr(3'd3, o);
        wr(3'd4, mode);
        wr(3'd0, 32'h0004_0004);
        np = p; nd = d; no = eff;
        pend_valid = 1'b1;
    endtask

    // launch from IDLE or DONE: the load happens one edge after the commit
    task automatic launch(logic [31:0] p, logic [31:0] d, logic [31:0] o,
                          logic [31:0] eff, logic [31:0] mode);
        track = 1'b0;
        stage(p, d, o, eff, mode);
        tick();
        chk("R2", 32'(pwm_out), 32'd0, "output before first count");
        ep = p; ed = d; eo = eff; kk = 0;
        pend_valid = 1'b0;
        track = 1'b1;
    endtask

    task automatic do_reset();
        track = 1'b0;
        pend_valid = 1'b0;
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL all: watchdog expired actual=%0d expected=0", 1);
        if (!finished) $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic        frozen;
        do_reset();

        // R1 reset state
        chk("R1", 32'(pwm_out), 32'd0, "pwm_out after reset");
        chk("R1", 32'(irq), 32'd0, "irq after reset");
        rd(3'd0, v); chk("R1", v, 32'd0, "enable reg after reset");
        rd(3'd1, v); chk("R1", v, 32'd0, "period reg after reset");

        // R7 masked enable write
        wr(3'd0, 32'h0003_0003);
        rd(3'd0, v); chk("R7", v, 32'd3, "enable bits set");

        launch(32'd10, 32'd3, 32'd2, 32'd2, 32'd0);
        rd(3'd0, v); chk("R6", v, 32'd3, "commit bit cleared after launch");
        repeat (25) tick();

        // vector table: staged changes applied at period ends
        for (int i = 0; i < NV; i++) begin
            cur_tag = (VEC[i][0] == 0) ? "R4" :
                      (VEC[i][2] != VEC[i][3]) ? "R3" : "R5";
            stage(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 32'd0);
            rd(3'd0, v); chk("R6", v, 32'd7, "commit pending readback");
            repeat (40) tick();
            rd(3'd0, v); chk("R6", v, 32'd3, "commit bit self-cleared");
        end

        // R11 readback of unlimited offset
        rd(3'd3, v); chk("R11", v, 32'd20, "offset readback");
        rd(3'd1, v); chk("R11", v, 32'd16, "period readback");

        // R5 staged write without commit has no effect
        cur_tag = "R5";
        wr(3'd2, 32'd9);
        repeat (34) tick();

        // R7 writes with no mask bits are ignored
        cur_tag = "R7";
        wr(3'd0, 32'h0000_0000);
        rd(3'd0, v); chk("R7", v, 32'd3, "unmasked write ignored");
        repeat (20) tick();

        // R8 freeze while output high (active counts 11..15)
        cur_tag = "R8";
        while (kk != 12) tick();
        wr(3'd0, 32'h0001_0000);
        track = 1'b0;
        frozen = pwm_out;
        chk("R8", 32'(frozen), 32'd1, "level at freeze");
        rd(3'd0, v); chk("R8", v, 32'd2, "output enable cleared");
        for (int j = 0; j < 6; j++) begin
            tick();
            chk("R8", 32'(pwm_out), 32'(frozen), "held during freeze");
        end
        wr(3'd0, 32'h0001_0001);
        chk("R8", 32'(pwm_out), 32'(frozen), "held on re-enable edge");
        track = 1'b1;
        repeat (30) tick();

        // R9 one-shot, three periods
        do_reset();
        chk("R1", 32'(pwm_out), 32'd0, "pwm_out after second reset");
        wr(3'd0, 32'h0003_0003);
        wr(3'd6, 32'd1);
        cur_tag = "R9";
        launch(32'd6, 32'd2, 32'd1, 32'd1, 32'h0003_0001);
        repeat (17) tick();
        chk("R10", 32'(irq), 32'd0, "irq before last period end");
        tick();
        chk("R9", 32'(irq), 32'd1, "irq at one-shot completion");
        track = 1'b0;
        for (int j = 0; j < 4; j++) begin
            tick();
            chk("R9", 32'(pwm_out), 32'd0, "output low in DONE");
        end

        // R10 status and mask
        rd(3'd5, v); chk("R10", v, 32'd1, "status set");
        wr(3'd6, 32'd0);
        chk("R10", 32'(irq), 32'd0, "irq masked");
        wr(3'd5, 32'd0);
        rd(3'd5, v); chk("R10", v, 32'd1, "write 0 keeps status");
        wr(3'd5, 32'd1);
        rd(3'd5, v); chk("R10", v, 32'd0, "write 1 clears status");
        wr(3'd6, 32'd1);
        chk("R10", 32'(irq), 32'd0, "irq low after clear");

        // R9 repetition count 0 runs one period, relaunch from DONE
        launch(32'd5, 32'd2, 32'd0, 32'd0, 32'h0000_0001);
        repeat (4) tick();
        chk("R9", 32'(irq), 32'd0, "no irq before single period ends");
        tick();
        chk("R9", 32'(irq), 32'd1, "irq after single period");
        track = 1'b0;
        tick();
        chk("R9", 32'(pwm_out), 32'd0, "output low after single period");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule